// File: doc/BRIEF.md
# I2C Transmit Command Admission Gate

This block sits between the processor's write path into the data/command register of a dual-role I2C controller and the transmit command FIFO. Every 9-bit command word (one direction flag above a data byte) is judged in the cycle it arrives. A write command is always queued. A read command is queued only when it does not clash with an earlier broadcast (general-call) transfer or with a read request from a remote master. A clashing read is dropped, and a sticky transmit-abort bit is raised in the raw interrupt vector.

The block keeps the two target-register bits it needs: the special-command enable and the general-call/start-byte select. It also keeps a flag for a general-call write that has been queued and a flag for a pending remote read request. Separately, it holds the last byte received from the bus so that the processor can read it back. The bus sequencer, the SCL timing and the FIFO storage are outside this block.

Top module: `i2c_cmd_gate`

## Requirements
- R1: A command with bit 8 = 0 (write) is always accepted. On the clock edge that samples it, `fifo_push` goes high for exactly one cycle and `fifo_data` = {1'b0, byte}.
- R2: A read command (bit 8 = 1) that is not rejected is queued as `fifo_data` = 9'h100. Its data bits 7:0 are ignored.
- R3: The target register write uses bit 11 as the special enable and bit 10 as the select (0 = general call). A write command queued while bit 11 = 1 and bit 10 = 0 marks a general call as sent. After that, read commands are rejected while bit 11 stays 1. Any target register write clears the mark, and it is then judged against the old target setting in that cycle.
- R4: A read command is rejected while a remote read request is pending.
- R5: A read command in the same cycle as `slv_rd_req` is rejected with no push. The request then becomes pending.
- R6: A remote read request is pending (raw interrupt bit 5) from the edge after `slv_rd_req` until a write command is accepted in a cycle without a new `slv_rd_req`.
- R7: Transmit-abort is raw interrupt bit 6. It is set on the edge after a rejection and holds until `abort_clr`. A rejection in the same cycle as `abort_clr` keeps it set.
- R8: `cpu_rd_data` shows the byte from the most recent `rx_valid` cycle, from the following edge onward.
- R9: After reset, `fifo_push`, `raw_intr` and `cpu_rd_data` are zero, and the general-call mark and the pending request are clear. Raw interrupt bits other than 5 and 6 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | Processor writes a command word |
| cpu_wr_data | input | 9 | Command word: bit 8 direction (1 = read), bits 7:0 byte |
| cpu_rd_data | output | 8 | Last received byte |
| tgt_wr_en | input | 1 | Processor rewrites the target register |
| tgt_wr_data | input | 12 | Target register value (bit 11 special, bit 10 select) |
| slv_rd_req | input | 1 | One-cycle read request from a remote master |
| rx_valid | input | 1 | A byte was received from the bus |
| rx_byte | input | 8 | Received byte |
| abort_clr | input | 1 | One-cycle clear of the transmit-abort bit |
| fifo_push | output | 1 | Push strobe to the command FIFO |
| fifo_data | output | 9 | Command word pushed |
| raw_intr | output | 8 | Raw interrupt vector (bit 6 abort, bit 5 read request) |

## Verification
The bench builds the gate with its default parameters: an 8-bit data byte, a 12-bit target register with the special and select bits at 11 and 10, and the interrupt bits at 6 and 5 of an 8-bit vector. The read payload is blanked. With these values every clash is reachable: a general call followed by a read, a read during a pending request, a read that coincides with a new request, and an abort that coincides with a clear. Directed sequences hit each clash. Random traffic, with target rewrites about one cycle in sixteen, covers armed and disarmed general-call states, back-to-back requests and mixed command streams against a cycle-level model.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_READ  = 2'd2
   } cmd_kind_e;

endpackage

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
   import i2c_cmd_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter bit ZERO_RD_PAYLOAD = 1'b1
) (
   input  logic              wr_en,
   input  logic [DATA_W:0]   wr_word,
   input  logic              gc_block,
   input  logic              rd_req_pend,
   input  logic              rd_req_now,
   output cmd_kind_e         kind,
   output logic              accept,
   output logic              reject,
   output logic [DATA_W:0]   payload
);

   localparam int DIR_BIT = DATA_W;

   logic conflict;

   always_comb begin
      if (!wr_en)               kind = CMD_NONE;
      else if (wr_word[DIR_BIT]) kind = CMD_READ;
      else                      kind = CMD_WRITE;
   end

   assign conflict = gc_block | rd_req_pend | rd_req_now;
   assign reject   = (kind == CMD_READ) && conflict;
   assign accept   = (kind != CMD_NONE) && !reject;

   generate
      if (ZERO_RD_PAYLOAD) begin : g_blank_rd
         always_comb begin
            if (wr_word[DIR_BIT]) payload = {1'b1, {DATA_W{1'b0}}};
            else                  payload = wr_word;
         end
      end else begin : g_pass_rd
         assign payload = wr_word;
      end
   endgenerate

endmodule

// File: rtl/i2c_cmd_ctx.sv
module i2c_cmd_ctx
   import i2c_cmd_pkg::*;
#(
   parameter int TGT_W       = 12,
   parameter int SPECIAL_BIT = 11,
   parameter int GCSEL_BIT   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgt_wr_en,
   input  logic [TGT_W-1:0]  tgt_wr_data,
   input  cmd_kind_e         kind,
   input  logic              accept,
   input  logic              slv_rd_req,
   output logic              gc_block,
   output logic              rd_req_pend
);

   logic special_q;
   logic gcsel_q;
   logic gc_sent_q;
   logic pend_q;
   logic wr_taken;
   logic gc_cfg;
   logic unused_tgt_bits;

   assign unused_tgt_bits = ^tgt_wr_data;
   assign wr_taken        = accept && (kind == CMD_WRITE);
   assign gc_cfg          = special_q && !gcsel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         special_q <= 1'b0;
         gcsel_q   <= 1'b0;
         gc_sent_q <= 1'b0;
      end else if (tgt_wr_en) begin
         special_q <= tgt_wr_data[SPECIAL_BIT];
         gcsel_q   <= tgt_wr_data[GCSEL_BIT];
         gc_sent_q <= 1'b0;
      end else if (wr_taken && gc_cfg) begin
         gc_sent_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= slv_rd_req | (pend_q & ~wr_taken);
   end

   assign gc_block    = gc_sent_q & special_q;
   assign rd_req_pend = pend_q;

endmodule

// File: rtl/i2c_abort_flag.sv
module i2c_abort_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= set | (flag & ~clr);
   end

endmodule

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   output logic [DATA_W-1:0] held
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held <= '0;
      else if (rx_valid) held <= rx_byte;
   end

endmodule

// File: rtl/i2c_cmd_gate.sv
module i2c_cmd_gate
   import i2c_cmd_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int TGT_W           = 12,
   parameter int SPECIAL_BIT     = 11,
   parameter int GCSEL_BIT       = 10,
   parameter int INTR_W          = 8,
   parameter int ABRT_BIT        = 6,
   parameter int RDREQ_BIT       = 5,
   parameter bit ZERO_RD_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic [DATA_W:0]   cpu_wr_data,
   output logic [DATA_W-1:0] cpu_rd_data,
   input  logic              tgt_wr_en,
   input  logic [TGT_W-1:0]  tgt_wr_data,
   input  logic              slv_rd_req,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              abort_clr,
   output logic              fifo_push,
   output logic [DATA_W:0]   fifo_data,
   output logic [INTR_W-1:0] raw_intr
);

   localparam int CMD_W = DATA_W + 1;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (SPECIAL_BIT >= TGT_W || GCSEL_BIT >= TGT_W) begin : g_bad_tgt
         $error("target bit positions exceed TGT_W");
      end
      if (SPECIAL_BIT == GCSEL_BIT) begin : g_bad_tgt_overlap
         $error("special and select bits must differ");
      end
      if (ABRT_BIT >= INTR_W || RDREQ_BIT >= INTR_W) begin : g_bad_intr
         $error("interrupt bit positions exceed INTR_W");
      end
      if (ABRT_BIT == RDREQ_BIT) begin : g_bad_intr_overlap
         $error("interrupt bits must differ");
      end
   endgenerate

   cmd_kind_e        kind;
   logic             accept;
   logic             reject;
   logic [CMD_W-1:0] payload;
   logic             gc_block;
   logic             rd_req_pend;
   logic             abort_q;

   i2c_cmd_decode #(
      .DATA_W          (DATA_W),
      .ZERO_RD_PAYLOAD (ZERO_RD_PAYLOAD)
   ) u_decode (
      .wr_en       (cpu_wr_en),
      .wr_word     (cpu_wr_data),
      .gc_block    (gc_block),
      .rd_req_pend (rd_req_pend),
      .rd_req_now  (slv_rd_req),
      .kind        (kind),
      .accept      (accept),
      .reject      (reject),
      .payload     (payload)
   );

   i2c_cmd_ctx #(
      .TGT_W       (TGT_W),
      .SPECIAL_BIT (SPECIAL_BIT),
      .GCSEL_BIT   (GCSEL_BIT)
   ) u_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .tgt_wr_en   (tgt_wr_en),
      .tgt_wr_data (tgt_wr_data),
      .kind        (kind),
      .accept      (accept),
      .slv_rd_req  (slv_rd_req),
      .gc_block    (gc_block),
      .rd_req_pend (rd_req_pend)
   );

   i2c_abort_flag u_abort (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (reject),
      .clr   (abort_clr),
      .flag  (abort_q)
   );

   i2c_rx_hold #(
      .DATA_W (DATA_W)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .held     (cpu_rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_push <= 1'b0;
         fifo_data <= '0;
      end else begin
         fifo_push <= accept;
         if (accept) fifo_data <= payload;
      end
   end

   generate
      for (genvar i = 0; i < INTR_W; i++) begin : g_intr
         if (i == ABRT_BIT) begin : g_abrt
            assign raw_intr[i] = abort_q;
         end else if (i == RDREQ_BIT) begin : g_rdreq
            assign raw_intr[i] = rd_req_pend;
         end else begin : g_spare
            assign raw_intr[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/i2c_cmd_gate_chk.sv
module i2c_cmd_gate_chk #(
   parameter int DATA_W          = 8,
   parameter int INTR_W          = 8,
   parameter int ABRT_BIT        = 6,
   parameter int RDREQ_BIT       = 5,
   parameter bit ZERO_RD_PAYLOAD = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr_en,
   input logic [DATA_W:0]   cpu_wr_data,
   input logic [DATA_W-1:0] cpu_rd_data,
   input logic              slv_rd_req,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_byte,
   input logic              abort_clr,
   input logic              fifo_push,
   input logic [DATA_W:0]   fifo_data,
   input logic [INTR_W-1:0] raw_intr
);

   logic              armed;
   logic [INTR_W-1:0] spare_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   always_comb begin
      spare_mask            = '1;
      spare_mask[ABRT_BIT]  = 1'b0;
      spare_mask[RDREQ_BIT] = 1'b0;
   end

   AST_WRITE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(cpu_wr_en && !cpu_wr_data[DATA_W]) |->
         fifo_push && !fifo_data[DATA_W] &&
         fifo_data[DATA_W-1:0] == $past(cpu_wr_data[DATA_W-1:0])); // R1

   AST_PUSH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      armed && fifo_push |-> $past(cpu_wr_en)); // R1

   generate
      if (ZERO_RD_PAYLOAD) begin : g_rd_blank
         AST_READ_PAYLOAD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_push && fifo_data[DATA_W] |-> fifo_data[DATA_W-1:0] == '0); // R2
      end
   endgenerate

   AST_PENDING_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(cpu_wr_en && cpu_wr_data[DATA_W] && raw_intr[RDREQ_BIT]) |->
         !fifo_push && raw_intr[ABRT_BIT]); // R4

   AST_SAME_CYCLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(cpu_wr_en && cpu_wr_data[DATA_W] && slv_rd_req) |->
         !fifo_push && raw_intr[ABRT_BIT] && raw_intr[RDREQ_BIT]); // R5

   AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(slv_rd_req) |-> raw_intr[RDREQ_BIT]); // R6

   AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(raw_intr[ABRT_BIT] && !abort_clr) |-> raw_intr[ABRT_BIT]); // R7

   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(abort_clr && !cpu_wr_en) |-> !raw_intr[ABRT_BIT]); // R7

   AST_RX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(rx_valid) |-> cpu_rd_data == $past(rx_byte)); // R8

   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_intr & spare_mask) == '0); // R9

endmodule

bind i2c_cmd_gate i2c_cmd_gate_chk #(
   .DATA_W          (DATA_W),
   .INTR_W          (INTR_W),
   .ABRT_BIT        (ABRT_BIT),
   .RDREQ_BIT       (RDREQ_BIT),
   .ZERO_RD_PAYLOAD (ZERO_RD_PAYLOAD)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_wr_en   (cpu_wr_en),
   .cpu_wr_data (cpu_wr_data),
   .cpu_rd_data (cpu_rd_data),
   .slv_rd_req  (slv_rd_req),
   .rx_valid    (rx_valid),
   .rx_byte     (rx_byte),
   .abort_clr   (abort_clr),
   .fifo_push   (fifo_push),
   .fifo_data   (fifo_data),
   .raw_intr    (raw_intr)
);

// File: tb/sim_i2c_cmd_gate.sv
`timescale 1ns/1ps
module sim_i2c_cmd_gate;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr_en = 1'b0;
   logic [8:0]  cpu_wr_data = '0;
   logic [7:0]  cpu_rd_data;
   logic        tgt_wr_en = 1'b0;
   logic [11:0] tgt_wr_data = '0;
   logic        slv_rd_req = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        abort_clr = 1'b0;
   logic        fifo_push;
   logic [8:0]  fifo_data;
   logic [7:0]  raw_intr;

   int vectors = 0;
   int miscompares = 0;

   // bench model state
   logic       m_special = 0, m_gcsel = 0, m_gc_sent = 0, m_pend = 0, m_abrt = 0;
   logic [7:0] m_rx = '0;
   logic [8:0] m_fdata = '0;
   logic       m_push = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_cmd_gate u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_data(cpu_rd_data),
      .tgt_wr_en(tgt_wr_en), .tgt_wr_data(tgt_wr_data),
      .slv_rd_req(slv_rd_req), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .abort_clr(abort_clr), .fifo_push(fifo_push), .fifo_data(fifo_data),
      .raw_intr(raw_intr)
   );

   function automatic logic read_rejected(logic wr, logic [8:0] d, logic req);
      return wr && d[8] && ((m_gc_sent && m_special) || m_pend || req);
   endfunction

   function automatic logic [7:0] expected_intr();
      logic [7:0] v = '0;
      v[6] = m_abrt;
      v[5] = m_pend;
      return v;
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // apply one cycle of inputs, advance model, compare after the edge
   task automatic step(string tag, logic wr, logic [8:0] d, logic tw, logic [11:0] td,
                       logic req, logic rv, logic [7:0] rb, logic clr);
      logic rej, is_wr;
      cpu_wr_en = wr; cpu_wr_data = d; tgt_wr_en = tw; tgt_wr_data = td;
      slv_rd_req = req; rx_valid = rv; rx_byte = rb; abort_clr = clr;
      rej   = read_rejected(wr, d, req);
      is_wr = wr && !d[8];
      m_push = wr && !rej;
      if (m_push) m_fdata = is_wr ? {1'b0, d[7:0]} : 9'h100;
      if (tw) begin
         m_special = td[11]; m_gcsel = td[10]; m_gc_sent = 1'b0;
      end else if (is_wr && m_special && !m_gcsel) m_gc_sent = 1'b1;
      m_pend = req | (m_pend & ~is_wr);
      m_abrt = rej | (m_abrt & ~clr);
      if (rv) m_rx = rb;
      @(posedge clk);
      #1;
      check(tag, (wr && d[8]) ? "R2 push" : "R1 push", 32'(fifo_push), 32'(m_push));
      if (m_push) check(tag, d[8] ? "R2 data" : "R1 data", 32'(fifo_data), 32'(m_fdata));
      check(tag, "R7/R6/R9 intr", 32'(raw_intr), 32'(expected_intr()));
      check(tag, "R8 rd", 32'(cpu_rd_data), 32'(m_rx));
      cpu_wr_en = 0; tgt_wr_en = 0; slv_rd_req = 0; rx_valid = 0; abort_clr = 0;
   endtask

   task automatic idle(string tag);
      step(tag, 0, 9'h0, 0, 12'h0, 0, 0, 8'h0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      check("R9", "push in reset", 32'(fifo_push), 0);
      check("R9", "intr in reset", 32'(raw_intr), 0);
      check("R9", "rd in reset", 32'(cpu_rd_data), 0);
      rst_n = 1'b1;
      idle("R9");

      // R1 write queued
      step("R1", 1, 9'h0A5, 0, 12'h0, 0, 0, 8'h0, 0);
      idle("R1");
      // R2 read payload blanked
      step("R2", 1, 9'h13C, 0, 12'h0, 0, 0, 8'h0, 0);
      // R3 general call then read
      step("R3", 0, 9'h0, 1, 12'h800, 0, 0, 8'h0, 0);
      step("R3", 1, 9'h055, 0, 12'h0, 0, 0, 8'h0, 0);
      step("R3", 1, 9'h100, 0, 12'h0, 0, 0, 8'h0, 0);
      check("R3", "abort after gc read", 32'(raw_intr[6]), 1);
      step("R7", 0, 9'h0, 0, 12'h0, 0, 0, 8'h0, 1);
      check("R7", "abort cleared", 32'(raw_intr[6]), 0);
      step("R3", 0, 9'h0, 1, 12'h000, 0, 0, 8'h0, 0);
      step("R3", 1, 9'h100, 0, 12'h0, 0, 0, 8'h0, 0);
      check("R3", "read accepted after rewrite", 32'(fifo_push), 1);
      // start-byte setting does not arm
      step("R3", 0, 9'h0, 1, 12'hC00, 0, 0, 8'h0, 0);
      step("R3", 1, 9'h011, 0, 12'h0, 0, 0, 8'h0, 0);
      step("R3", 1, 9'h1FF, 0, 12'h0, 0, 0, 8'h0, 0);
      check("R3", "start byte no block", 32'(fifo_push), 1);
      // R4 pending request blocks read
      step("R6", 0, 9'h0, 0, 12'h0, 1, 0, 8'h0, 0);
      step("R4", 1, 9'h100, 0, 12'h0, 0, 0, 8'h0, 0);
      check("R4", "read dropped", 32'(fifo_push), 0);
      step("R6", 1, 9'h077, 0, 12'h0, 0, 0, 8'h0, 0);
      check("R6", "pending serviced", 32'(raw_intr[5]), 0);
      // R5 same-cycle request
      step("R5", 1, 9'h100, 0, 12'h0, 1, 0, 8'h0, 1);
      check("R5", "pending kept", 32'(raw_intr[5]), 1);
      check("R7", "abort wins over clear", 32'(raw_intr[6]), 1);
      step("R6", 1, 9'h022, 0, 12'h0, 1, 0, 8'h0, 0);
      check("R6", "new request survives write", 32'(raw_intr[5]), 1);
      step("R6", 1, 9'h023, 0, 12'h0, 0, 0, 8'h0, 1);
      // R8 received byte
      step("R8", 0, 9'h0, 0, 12'h0, 0, 1, 8'hC3, 0);
      check("R8", "rx byte", 32'(cpu_rd_data), 32'hC3);
      idle("R8");

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         logic wr, tw, req, rv, clr;
         wr  = ($urandom % 3) != 0;
         tw  = ($urandom % 16) == 0;
         req = ($urandom % 10) == 0;
         rv  = ($urandom % 4) == 0;
         clr = ($urandom % 6) == 0;
         step("random", wr, 9'($urandom), tw, 12'($urandom), req, rv, 8'($urandom), clr);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule